// File: doc/BRIEF.md
# ADC Calibration Correction Datapath

This block sits after the decimation filter of a sigma-delta converter. It turns each wide raw conversion result into a calibrated output code. It keeps two coefficients: a signed zero-scale offset and an unsigned gain factor. Each raw sample first has the offset removed. The difference is then scaled by the gain. A single rounding step brings the product down to the selected word size, and the value is clamped to the code range.

Two control inputs set the output. One chooses a 16-bit or 24-bit word. The other chooses straight binary coding for single-sided inputs or offset-binary coding for two-sided inputs. Both control inputs travel with the sample they were sampled with. Either coefficient can be loaded by the host or by an on-chip calibration sequencer. A load changes only the samples accepted after it. Samples flow through three registered stages with a valid flag and no stall.

Top module: `adc_cal_correct`

## Requirements
- R1: The output equals round((raw - offset) * gain). The offset is removed before the gain is applied. The raw value and the offset are 33-bit two's complement.
- R2: The gain is unsigned with 23 fraction bits: 0x800000 is 1.0, 0xC00000 is 1.5 and 0x1000000 is 2.0. It is taken from the low 25 bits of the write data.
- R3: A raw value of 2^32 is the single-sided full scale.
  - When mode_wide is 1, the output is 24 bits.
  - When mode_wide is 0, the output is 16 bits in out_data[15:0], and out_data[23:16] are 0.
- R4: Rounding is done once, half-up: add one half of the output LSB, then shift right arithmetically.
- R5: When mode_bipolar is 0, the code is straight binary. Negative results give all zeros. Results above the top code give all ones.
- R6: When mode_bipolar is 1, the code is offset binary: a corrected value of zero gives 2^(W-1), and the LSB is 2^(33-W) raw units. The value is clamped to 0 and all ones after the bias is added.
- R7: out_valid is high exactly three cycles after in_valid was high.
- R8: mode_bipolar and mode_wide are captured with each sample. A mode change alters only the coding of later samples, never the samples already in flight.
- R9: A host write with host_sel = 0 loads the offset. A host write with host_sel = 1 loads the gain. With no write, both coefficients hold.
- R10: If the host and the sequencer write the same coefficient in one cycle, the sequencer value is stored. Writes to different coefficients in one cycle both take effect.
- R11: A coefficient write applies from the first sample accepted in a later cycle. Samples accepted in the same cycle as the write, or earlier, use the old values.
- R12: After reset, the offset is 0, the gain is 1.0, out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw sample present |
| in_raw | input | 33 | Raw result, two's complement |
| mode_bipolar | input | 1 | 1 = offset binary, 0 = straight binary |
| mode_wide | input | 1 | 1 = 24-bit word, 0 = 16-bit word |
| host_we | input | 1 | Host coefficient write |
| host_sel | input | 1 | Host target: 0 offset, 1 gain |
| host_wdata | input | 33 | Host write data |
| seq_we | input | 1 | Sequencer coefficient write |
| seq_sel | input | 1 | Sequencer target: 0 offset, 1 gain |
| seq_wdata | input | 33 | Sequencer write data |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | 24 | Corrected code, right-justified |

## Verification
The assertions assume the following about the inputs:
- in_valid, the mode inputs and both write ports are driven to known levels in every cycle once reset is released.
- in_valid is held low during reset, so the three-cycle latency check never depends on values from before reset.

The stimulus changes every input only at the falling clock edge. It issues each coefficient write as a one-cycle pulse. Overlaps between writes, mode changes and samples in flight are created only on purpose, in the streaming and priority scenarios.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

    typedef enum logic {
        COEF_OFFSET = 1'b0,
        COEF_GAIN   = 1'b1
    } coef_sel_e;

    typedef struct packed {
        logic bipolar;
        logic wide;
    } code_mode_t;

    // Output word width chosen by the mode.
    function automatic int unsigned word_bits(code_mode_t m, int unsigned narrow,
                                              int unsigned full);
        return m.wide ? full : narrow;
    endfunction

    // Total right shift from product to output LSB.
    function automatic int unsigned drop_bits(code_mode_t m, int unsigned base,
                                              int unsigned narrow, int unsigned full);
        return base + (m.wide ? 0 : (full - narrow)) + (m.bipolar ? 1 : 0);
    endfunction

endpackage

// File: rtl/adc_cal_coef.sv
module adc_cal_coef
    import adc_cal_pkg::*;
#(
    parameter int RAW_W     = 33,
    parameter int GAIN_W    = 25,
    parameter int GAIN_FRAC = 23
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    host_we,
    input  coef_sel_e               host_sel,
    input  logic [RAW_W-1:0]        host_wdata,
    input  logic                    seq_we,
    input  coef_sel_e               seq_sel,
    input  logic [RAW_W-1:0]        seq_wdata,
    output logic signed [RAW_W-1:0] offset_q,
    output logic [GAIN_W-1:0]       gain_q
);
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0;
            gain_q   <= GAIN_ONE;
        end else begin
            if (host_we) begin
                if (host_sel == COEF_OFFSET) offset_q <= host_wdata;
                else                         gain_q   <= host_wdata[GAIN_W-1:0];
            end
            // Sequencer after host: it wins a same-register collision.
            if (seq_we) begin
                if (seq_sel == COEF_OFFSET) offset_q <= seq_wdata;
                else                        gain_q   <= seq_wdata[GAIN_W-1:0];
            end
        end
    end

    p_host_offset_r9: assert property (@(posedge clk) disable iff (rst)
        host_we && host_sel == COEF_OFFSET && !(seq_we && seq_sel == COEF_OFFSET)
        |=> offset_q == $past(host_wdata));

    p_seq_wins_r10: assert property (@(posedge clk) disable iff (rst)
        seq_we && seq_sel == COEF_GAIN |=> gain_q == $past(seq_wdata[GAIN_W-1:0]));

    p_coef_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !host_we && !seq_we |=> $stable(offset_q) && $stable(gain_q));

endmodule

// File: rtl/adc_cal_sub.sv
module adc_cal_sub
    import adc_cal_pkg::*;
#(
    parameter int RAW_W  = 33,
    parameter int GAIN_W = 25,
    localparam int DIFF_W = RAW_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [RAW_W-1:0]         in_raw,
    input  code_mode_t               in_mode,
    input  logic signed [RAW_W-1:0]  offset,
    input  logic [GAIN_W-1:0]        gain,
    output logic                     s1_valid,
    output logic signed [DIFF_W-1:0] s1_diff,
    output logic [GAIN_W-1:0]        s1_gain,
    output code_mode_t               s1_mode
);
    logic signed [DIFF_W-1:0] diff_c;

    always_comb begin
        diff_c = DIFF_W'($signed(in_raw)) - DIFF_W'(offset);
    end

    // Gain and mode are snapshotted with the sample so that later
    // writes cannot reach it while it is in flight.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_diff  <= '0;
            s1_gain  <= '0;
            s1_mode  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_diff <= diff_c;
                s1_gain <= gain;
                s1_mode <= in_mode;
            end
        end
    end

endmodule

// File: rtl/adc_cal_mul.sv
module adc_cal_mul
    import adc_cal_pkg::*;
#(
    parameter int DIFF_W = 34,
    parameter int GAIN_W = 25,
    localparam int PROD_W = DIFF_W + GAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_valid,
    input  logic signed [DIFF_W-1:0] s1_diff,
    input  logic [GAIN_W-1:0]        s1_gain,
    input  code_mode_t               s1_mode,
    output logic                     s2_valid,
    output logic signed [PROD_W-1:0] s2_prod,
    output code_mode_t               s2_mode
);
    logic signed [PROD_W-1:0] prod_c;

    always_comb begin
        prod_c = PROD_W'(s1_diff) * PROD_W'($signed({1'b0, s1_gain}));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_prod  <= '0;
            s2_mode  <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_prod <= prod_c;
                s2_mode <= s1_mode;
            end
        end
    end

endmodule

// File: rtl/adc_cal_fmt.sv
module adc_cal_fmt
    import adc_cal_pkg::*;
#(
    parameter int RAW_W     = 33,
    parameter int GAIN_FRAC = 23,
    parameter int PROD_W    = 60,
    parameter int OUT_MIN   = 16,
    parameter int OUT_MAX   = 24,
    localparam int SH_BASE  = GAIN_FRAC + RAW_W - 1 - OUT_MAX
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s2_valid,
    input  logic signed [PROD_W-1:0] s2_prod,
    input  code_mode_t               s2_mode,
    output logic                     out_valid,
    output logic [OUT_MAX-1:0]       out_data
);
    int unsigned              sh;
    int unsigned              w;
    logic signed [PROD_W-1:0] half_lsb;
    logic signed [PROD_W-1:0] rounded;
    logic signed [PROD_W-1:0] scaled;
    logic signed [PROD_W-1:0] bias;
    logic signed [PROD_W-1:0] coded;
    logic signed [PROD_W-1:0] top_code;
    logic [OUT_MAX-1:0]       code_c;

    always_comb begin
        sh       = drop_bits(s2_mode, SH_BASE, OUT_MIN, OUT_MAX);
        w        = word_bits(s2_mode, OUT_MIN, OUT_MAX);
        half_lsb = $signed(PROD_W'(1) << (sh - 1));
        rounded  = s2_prod + half_lsb;
        scaled   = rounded >>> sh;
        bias     = s2_mode.bipolar ? $signed(PROD_W'(1) << (w - 1)) : $signed(PROD_W'(0));
        coded    = scaled + bias;
        top_code = $signed((PROD_W'(1) << w) - PROD_W'(1));
        if (coded < $signed(PROD_W'(0))) begin
            code_c = '0;
        end else if (coded > top_code) begin
            code_c = top_code[OUT_MAX-1:0];
        end else begin
            code_c = coded[OUT_MAX-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) out_data <= code_c;
        end
    end

    p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        s2_valid && !s2_mode.wide |=> out_data[OUT_MAX-1:OUT_MIN] == '0);

    p_uni_neg_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        s2_valid && !s2_mode.bipolar && s2_prod < 0 |=> out_data == '0);

    p_bip_midcode_r6: assert property (@(posedge clk) disable iff (rst)
        s2_valid && s2_mode.bipolar && s2_mode.wide && s2_prod == 0
        |=> out_data == (OUT_MAX'(1) << (OUT_MAX - 1)));

endmodule

// File: rtl/adc_cal_correct.sv
module adc_cal_correct
    import adc_cal_pkg::*;
#(
    parameter int RAW_W     = 33,
    parameter int GAIN_W    = 25,
    parameter int GAIN_FRAC = 23,
    parameter int OUT_MIN   = 16,
    parameter int OUT_MAX   = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [RAW_W-1:0]   in_raw,
    input  logic               mode_bipolar,
    input  logic               mode_wide,
    input  logic               host_we,
    input  logic               host_sel,
    input  logic [RAW_W-1:0]   host_wdata,
    input  logic               seq_we,
    input  logic               seq_sel,
    input  logic [RAW_W-1:0]   seq_wdata,
    output logic               out_valid,
    output logic [OUT_MAX-1:0] out_data
);
    localparam int DIFF_W = RAW_W + 1;
    localparam int PROD_W = DIFF_W + GAIN_W + 1;

    logic signed [RAW_W-1:0]  offset_q;
    logic [GAIN_W-1:0]        gain_q;
    code_mode_t               in_mode;
    logic                     s1_valid;
    logic signed [DIFF_W-1:0] s1_diff;
    logic [GAIN_W-1:0]        s1_gain;
    code_mode_t               s1_mode;
    logic                     s2_valid;
    logic signed [PROD_W-1:0] s2_prod;
    code_mode_t               s2_mode;

    always_comb begin
        in_mode.bipolar = mode_bipolar;
        in_mode.wide    = mode_wide;
    end

    adc_cal_coef #(.RAW_W(RAW_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_coef (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_sel(coef_sel_e'(host_sel)), .host_wdata(host_wdata),
        .seq_we(seq_we), .seq_sel(coef_sel_e'(seq_sel)), .seq_wdata(seq_wdata),
        .offset_q(offset_q), .gain_q(gain_q)
    );

    adc_cal_sub #(.RAW_W(RAW_W), .GAIN_W(GAIN_W)) u_sub (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_raw(in_raw), .in_mode(in_mode),
        .offset(offset_q), .gain(gain_q),
        .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_gain(s1_gain), .s1_mode(s1_mode)
    );

    adc_cal_mul #(.DIFF_W(DIFF_W), .GAIN_W(GAIN_W)) u_mul (
        .clk(clk), .rst(rst),
        .s1_valid(s1_valid), .s1_diff(s1_diff), .s1_gain(s1_gain), .s1_mode(s1_mode),
        .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_mode(s2_mode)
    );

    adc_cal_fmt #(.RAW_W(RAW_W), .GAIN_FRAC(GAIN_FRAC), .PROD_W(PROD_W),
                  .OUT_MIN(OUT_MIN), .OUT_MAX(OUT_MAX)) u_fmt (
        .clk(clk), .rst(rst),
        .s2_valid(s2_valid), .s2_prod(s2_prod), .s2_mode(s2_mode),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        since_rst == 2'd3 |-> out_valid == $past(in_valid, 3));

    p_out_known_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_data));

endmodule

// File: tb/adc_cal_correct_tb.sv
module adc_cal_correct_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [32:0] in_raw = '0;
    logic        mode_bipolar = 1'b0;
    logic        mode_wide = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [32:0] host_wdata = '0;
    logic        seq_we = 1'b0;
    logic        seq_sel = 1'b0;
    logic [32:0] seq_wdata = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_cal_correct u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_raw(in_raw),
        .mode_bipolar(mode_bipolar), .mode_wide(mode_wide),
        .host_we(host_we), .host_sel(host_sel), .host_wdata(host_wdata),
        .seq_we(seq_we), .seq_sel(seq_sel), .seq_wdata(seq_wdata),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Send one sample, confirm 3-cycle latency and the code.
    task automatic run(logic [32:0] raw, bit bip, bit wide, string req, longint exp);
        @(negedge clk);
        in_valid = 1'b1; in_raw = raw; mode_bipolar = bip; mode_wide = wide;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 early valid", longint'(out_valid), 0);
        @(negedge clk);
        chk("R7 valid", longint'(out_valid), 1);
        chk(req, longint'(out_data), exp);
    endtask

    task automatic wr(bit seq, bit sel, logic [32:0] data);
        @(negedge clk);
        if (seq) begin seq_we = 1'b1; seq_sel = sel; seq_wdata = data; end
        else     begin host_we = 1'b1; host_sel = sel; host_wdata = data; end
        @(negedge clk);
        seq_we = 1'b0; host_we = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R12 out_valid in reset", longint'(out_valid), 0);
        chk("R12 out_data in reset", longint'(out_data), 0);
        rst = 1'b0;
        run(33'h100, 0, 1, "R12 default gain 1.0 offset 0", 1);
    endtask

    task automatic t_unipolar();
        run(33'h12345600, 0, 1, "R5 uni mid", 24'h123456);
        run(33'h80000000, 0, 1, "R3 uni half scale", 24'h800000);
        run(33'h0FFFFFFFF, 0, 1, "R5 uni top clamps", 24'hFFFFFF);
        run(33'h1FFFFF000, 0, 1, "R5 uni negative clamps", 0);
    endtask

    task automatic t_rounding();
        run(33'h17F, 0, 1, "R4 below half", 1);
        run(33'h180, 0, 1, "R4 exactly half rounds up", 2);
        run(33'h1FFFFFF00, 1, 1, "R4 bip minus half rounds up", 24'h800000);
        run(33'h1FFFFFEFF, 1, 1, "R4 bip beyond minus half", 24'h7FFFFF);
    endtask

    task automatic t_bipolar();
        run(33'h0, 1, 1, "R6 bip zero midcode", 24'h800000);
        run(33'h12345600, 1, 1, "R6 bip positive", 24'h891A2B);
        run(33'h100000000, 1, 1, "R6 bip min clamps", 0);
        run(33'h0FFFFFFFF, 1, 1, "R6 bip max clamps", 24'hFFFFFF);
    endtask

    task automatic t_narrow();
        run(33'h10000, 0, 0, "R3 narrow one LSB", 1);
        run(33'h12345678, 0, 0, "R3 narrow value", 16'h1234);
        run(33'h0, 1, 0, "R3 narrow bip midcode", 16'h8000);
        run(33'h0FFFFFFFF, 0, 0, "R3 narrow clamp upper zero", 16'hFFFF);
    endtask

    task automatic t_coefs();
        wr(0, 0, 33'h300);
        run(33'h500, 0, 1, "R9 host offset", 2);
        wr(0, 0, 33'h1FFFFFE00);
        run(33'h100, 0, 1, "R9 negative offset", 3);
        wr(0, 1, 33'hC00000);
        wr(0, 0, 33'h0);
        run(33'h200, 0, 1, "R2 gain 1.5", 3);
        wr(0, 1, 33'h1000000);
        wr(0, 0, 33'h100);
        run(33'h300, 0, 1, "R1 offset before gain", 4);
        wr(0, 0, 33'h0);
        run(33'h90000000, 0, 1, "R5 gain overflow clamps", 24'hFFFFFF);
        run(33'h100, 0, 1, "R9 coefficients held", 2);
    endtask

    task automatic t_priority();
        @(negedge clk);
        host_we = 1'b1; host_sel = 1'b0; host_wdata = 33'h1000;
        seq_we = 1'b1; seq_sel = 1'b0; seq_wdata = 33'h200;
        @(negedge clk);
        host_we = 1'b0; seq_we = 1'b0;
        run(33'h400, 0, 1, "R10 sequencer wins offset", 4);
        @(negedge clk);
        host_we = 1'b1; host_sel = 1'b1; host_wdata = 33'h800000;
        seq_we = 1'b1; seq_sel = 1'b0; seq_wdata = 33'h0;
        @(negedge clk);
        host_we = 1'b0; seq_we = 1'b0;
        run(33'h300, 0, 1, "R10 different registers both", 3);
    endtask

    // Streamed samples with a mode change and a gain write in flight.
    task automatic t_stream();
        @(negedge clk);
        in_valid = 1'b1; in_raw = 33'h100; mode_bipolar = 1'b0; mode_wide = 1'b1;
        @(negedge clk);
        mode_bipolar = 1'b1;
        host_we = 1'b1; host_sel = 1'b1; host_wdata = 33'h1000000;
        @(negedge clk);
        host_we = 1'b0; mode_bipolar = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 first sample keeps uni coding", longint'(out_data), 1);
        @(negedge clk);
        chk("R11 same-cycle sample uses old gain", longint'(out_data), 24'h800001);
        @(negedge clk);
        chk("R11 later sample uses new gain", longint'(out_data), 2);
        chk("R7 stream valid", longint'(out_valid), 1);
        @(negedge clk);
        chk("R7 stream ends", longint'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_unipolar();
        t_rounding();
        t_bipolar();
        t_narrow();
        t_coefs();
        t_priority();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule